// File: doc/BRIEF.md
# Indexed Configuration Register Space for a Multi-Function I/O Controller

This block is the configuration register file of a multi-function I/O controller, reached through two adjacent byte ports on a host I/O bus. The host writes a register number to the index port. It then reads or writes that register through the data port at the next address up.

Global registers hold the following:
- a read-only chip identifier
- a configuration byte whose low bit enables the whole chip
- a logical-unit selector

Registers at index 0x30 and above are banked by the selected unit. Only the GPIO unit (unit 7) is implemented. Its bank holds:
- an activate byte
- a 16-bit runtime base address
- a packed pin selector
- per-pin configuration and event bytes for 32 pins

The GPIO base address and the combined enable are exported to the runtime GPIO block. Other units read as zero.

Top module: `sio_cfg_space`

## Requirements
- R1: A write at the index port (0x002E, or 0x004E when `ALT_LOC`=1) stores the byte as the current index. A read there returns the stored index, which resets to 0x00.
- R2: Index 0x20 reads 0xE5 when `ID_VARIANT`=0 and 0xE9 when `ID_VARIANT`=1. Writes to index 0x20 have no effect.
- R3: Index 0x21 is a read/write byte that resets to 0x01. Its bit 0 is the chip enable.
- R4: Index 0x07 is a read/write unit selector that resets to 0x00. Value 0x07 selects the GPIO unit.
- R5: With the GPIO unit selected, index 0x30 is its read/write activate byte, which resets to 0x01. `gpio_en` is high exactly when chip enable bit 0 is 1 and the activate byte is nonzero.
- R6: With the GPIO unit selected, index 0x60 holds the high byte and index 0x61 the low byte of `gpio_base`. Both reset to `GPIO_BASE_RST`.
- R7: With the GPIO unit selected, index 0xF0 is the pin selector. Only bits 5:4 (port) and 2:0 (bit) are kept, and the other bits read 0. The selected pin number is port*8+bit.
- R8: With the GPIO unit selected, index 0xF1 reads or writes the configuration byte of the selected pin, and index 0xF2 its event byte. Each of the 32 pins has its own pair, and all reset to 0x00.
- R9: A read of an unimplemented index, or of any index 0x30 and above while a unit other than 0x07 is selected, returns 0x00. Writes there change no readable state.
- R10: `io_rdata` is 0x00 unless `io_rd` is high at the index or data port. Accesses at any other address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Host I/O address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe, committed at the clock edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from the current address and state |
| gpio_base | output | 16 | GPIO unit runtime base address |
| gpio_en | output | 1 | Chip enabled and GPIO unit active |

## Verification
A stale or wrong index shows at the data port on the very next read: the host gets another register's value or a zero. A wrong unit selection shows the same way, since banked reads return zero or wrong bytes. A mis-decoded pin selector writes into a neighbouring pin's slot. That error stays hidden until that pin is selected and read back, so the bench sweeps all 32 pins after scattered writes. Enable and base-address corruption reach `gpio_en` and `gpio_base` one clock after the offending write, and the bench compares them on every cycle.

// File: rtl/sio_cfg_space.sv
module sio_cfg_space #(
  parameter bit          ALT_LOC       = 1'b0,
  parameter bit          ID_VARIANT    = 1'b0,
  parameter logic [15:0] GPIO_BASE_RST = 16'h0E00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic [15:0] gpio_base,
  output logic        gpio_en
);
  localparam logic [15:0] CMD_PORT  = ALT_LOC ? 16'h004E : 16'h002E;
  localparam logic [15:0] DATA_PORT = CMD_PORT + 16'd1;
  localparam logic [7:0]  CHIP_ID   = ID_VARIANT ? 8'hE9 : 8'hE5;
  localparam logic [7:0]  GPIO_UNIT = 8'h07;
  localparam int          NPIN      = 32;

  logic [7:0] idx, unit, cfg1, act, base_hi, base_lo, psel;
  logic [7:0] pin_cfg [NPIN];
  logic [7:0] pin_evt [NPIN];
  logic [7:0] rd_val;

  wire       cmd_hit  = (io_addr == CMD_PORT);
  wire       dat_hit  = (io_addr == DATA_PORT);
  wire       wr_idx   = io_wr & cmd_hit;
  wire       wr_dat   = io_wr & dat_hit;
  wire       gpio_sel = (unit == GPIO_UNIT);
  wire [4:0] pin      = {psel[5:4], psel[2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= 8'h00;
      unit    <= 8'h00;
      cfg1    <= 8'h01;
      act     <= 8'h01;
      base_hi <= GPIO_BASE_RST[15:8];
      base_lo <= GPIO_BASE_RST[7:0];
      psel    <= 8'h00;
      for (int i = 0; i < NPIN; i++) begin
        pin_cfg[i] <= 8'h00;
        pin_evt[i] <= 8'h00;
      end
    end else begin
      if (wr_idx) idx <= io_wdata;
      if (wr_dat) begin
        case (idx)
          8'h07: unit <= io_wdata;
          8'h21: cfg1 <= io_wdata;
          default: ;
        endcase
        if (gpio_sel) begin
          case (idx)
            8'h30: act     <= io_wdata;
            8'h60: base_hi <= io_wdata;
            8'h61: base_lo <= io_wdata;
            8'hF0: psel    <= io_wdata & 8'h37;
            8'hF1: pin_cfg[pin] <= io_wdata;
            8'hF2: pin_evt[pin] <= io_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_val = 8'h00;
    case (idx)
      8'h07: rd_val = unit;
      8'h20: rd_val = CHIP_ID;
      8'h21: rd_val = cfg1;
      default: ;
    endcase
    if (gpio_sel) begin
      case (idx)
        8'h30: rd_val = act;
        8'h60: rd_val = base_hi;
        8'h61: rd_val = base_lo;
        8'hF0: rd_val = psel;
        8'hF1: rd_val = pin_cfg[pin];
        8'hF2: rd_val = pin_evt[pin];
        default: ;
      endcase
    end
  end

  assign io_rdata  = !io_rd  ? 8'h00 :
                     cmd_hit ? idx   :
                     dat_hit ? rd_val : 8'h00;
  assign gpio_base = {base_hi, base_lo};
  assign gpio_en   = cfg1[0] & (act != 8'h00);
endmodule

// File: rtl/sio_cfg_space_chk.sv
module sio_cfg_space_chk #(
  parameter bit ALT_LOC    = 1'b0,
  parameter bit ID_VARIANT = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] io_addr,
  input logic        io_rd,
  input logic        io_wr,
  input logic [7:0]  io_wdata,
  input logic [7:0]  io_rdata,
  input logic [15:0] gpio_base,
  input logic        gpio_en,
  input logic [7:0]  idx,
  input logic [7:0]  unit
);
  localparam logic [15:0] CP = ALT_LOC ? 16'h004E : 16'h002E;

  assert_index_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == CP) |=> (idx == $past(io_wdata)));

  assert_chip_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == CP + 16'd1 && idx == 8'h20) |->
    (io_rdata == (ID_VARIANT ? 8'hE9 : 8'hE5)));

  assert_chip_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == CP + 16'd1 && idx == 8'h21 && !io_wdata[0]) |=> !gpio_en);

  assert_base_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(gpio_base));

  assert_stub_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == CP + 16'd1 && idx >= 8'h30 && unit != 8'h07) |-> (io_rdata == 8'h00));

  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == 8'h00));
endmodule

bind sio_cfg_space sio_cfg_space_chk #(.ALT_LOC(ALT_LOC), .ID_VARIANT(ID_VARIANT)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .gpio_base(gpio_base),
  .gpio_en(gpio_en), .idx(idx), .unit(unit)
);

// File: tb/tb_sio_cfg_space.sv
module tb_sio_cfg_space;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  io_rdata;
  logic [15:0] gpio_base;
  logic        gpio_en;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural model state
  int m_idx, m_unit, m_cfg1, m_act, m_base, m_psel;
  int m_cfg [32];
  int m_evt [32];

  always #10 clk = ~clk;

  sio_cfg_space dut (.clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .gpio_base(gpio_base), .gpio_en(gpio_en));

  function automatic int m_pin();
    return ((m_psel / 16) % 4) * 8 + (m_psel % 8);
  endfunction

  function automatic int m_read(input int a);
    if (a == 'h2E) return m_idx;
    if (a != 'h2F) return 0;
    if (m_idx == 'h07) return m_unit;
    if (m_idx == 'h20) return 'hE5;
    if (m_idx == 'h21) return m_cfg1;
    if (m_unit != 7) return 0;
    if (m_idx == 'h30) return m_act;
    if (m_idx == 'h60) return m_base / 256;
    if (m_idx == 'h61) return m_base % 256;
    if (m_idx == 'hF0) return m_psel;
    if (m_idx == 'hF1) return m_cfg[m_pin()];
    if (m_idx == 'hF2) return m_evt[m_pin()];
    return 0;
  endfunction

  task automatic m_write(input int a, input int d);
    if (a == 'h2E) begin m_idx = d; return; end
    if (a != 'h2F) return;
    if (m_idx == 'h07) m_unit = d;
    else if (m_idx == 'h21) m_cfg1 = d;
    else if (m_unit == 7) begin
      if (m_idx == 'h30) m_act = d;
      else if (m_idx == 'h60) m_base = d * 256 + m_base % 256;
      else if (m_idx == 'h61) m_base = (m_base / 256) * 256 + d;
      else if (m_idx == 'hF0) m_psel = d & 'h37;
      else if (m_idx == 'hF1) m_cfg[m_pin()] = d;
      else if (m_idx == 'hF2) m_evt[m_pin()] = d;
    end
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one bus cycle; outputs compared mid-cycle, model updated at the edge
  task automatic cyc(input string tag, input int a, input bit rd, input bit wr, input int d);
    @(negedge clk);
    io_addr = a[15:0]; io_rd = rd; io_wr = wr; io_wdata = d[7:0];
    #2;
    check(tag, io_rdata, rd ? m_read(a) : 0);
    check("R5", gpio_en, ((m_cfg1 % 2) == 1) && (m_act != 0));
    check("R6", gpio_base, m_base);
    @(posedge clk);
    if (wr) m_write(a, d);
  endtask

  task automatic wreg(input string tag, input int i, input int d);
    cyc("R1", 'h2E, 0, 1, i);
    cyc(tag, 'h2F, 0, 1, d);
  endtask

  task automatic rreg(input string tag, input int i);
    cyc("R1", 'h2E, 0, 1, i);
    cyc(tag, 'h2F, 1, 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_idx = 0; m_unit = 0; m_cfg1 = 1; m_act = 1; m_base = 'h0E00; m_psel = 0;
    for (int i = 0; i < 32; i++) begin m_cfg[i] = 0; m_evt[i] = 0; end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    cyc("R1", 'h2E, 1, 0, 0);                  // reset index
    rreg("R2", 'h20);                          // chip id
    rreg("R3", 'h21);                          // cfg1 reset 0x01
    rreg("R4", 'h07);                          // unit reset 0x00
    rreg("R9", 'h30);                          // unit 0 bank reads zero
    wreg("R9", 'h60, 'h12);                    // ignored with no unit
    wreg("R2", 'h20, 'h55);                    // id write ignored
    rreg("R2", 'h20);
    wreg("R4", 'h07, 'h07);                    // select GPIO
    rreg("R4", 'h07);
    rreg("R5", 'h30);
    rreg("R6", 'h60);
    rreg("R6", 'h61);
    wreg("R3", 'h21, 'h00);                    // chip off
    rreg("R3", 'h21);
    wreg("R3", 'h21, 'hA1);
    wreg("R5", 'h30, 'h00);                    // unit off
    wreg("R5", 'h30, 'h04);
    wreg("R6", 'h60, 'hBE);
    wreg("R6", 'h61, 'hEF);
    rreg("R6", 'h61);
    wreg("R7", 'hF0, 'hFF);                    // masked to 0x37
    rreg("R7", 'hF0);
    for (int p = 0; p < 32; p++) begin
      wreg("R7", 'hF0, ((p * 2) & 'hF0) | (p & 7));
      wreg("R8", 'hF1, p * 7 + 3);
      wreg("R8", 'hF2, 255 - p);
    end
    for (int p = 31; p >= 0; p--) begin
      wreg("R7", 'hF0, ((p * 2) & 'hF0) | (p & 7));
      rreg("R8", 'hF1);
      cyc("R8", 'h2F, 1, 0, 0);
      rreg("R8", 'hF2);
    end
    rreg("R9", 'h55);                          // unimplemented index
    wreg("R9", 'h55, 'h99);
    wreg("R4", 'h07, 'h0D);                    // stub unit
    rreg("R9", 'h30);
    wreg("R9", 'h30, 'h00);
    wreg("R9", 'h61, 'h00);
    wreg("R9", 'hF1, 'h77);
    rreg("R9", 'hF1);
    wreg("R4", 'h07, 'h0E);
    rreg("R9", 'h60);
    wreg("R4", 'h07, 'h07);
    rreg("R9", 'h30);                          // GPIO unit unchanged
    rreg("R9", 'h61);
    rreg("R9", 'hF1);
    cyc("R10", 'h4E, 0, 1, 'h21);              // other port ignored
    cyc("R10", 'h4F, 0, 1, 'h00);
    cyc("R10", 'h4F, 1, 0, 0);
    cyc("R10", 'h2F, 0, 0, 0);                 // no strobe, zero data
    cyc("R10", 'h2E, 1, 0, 0);
    rreg("R10", 'hF1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule